// File: doc/BRIEF.md
# Bus Address Phase Transmitter

This block sends the address byte that opens an I2C transfer. A controller gives it a start pulse. On that pulse the block latches a 7-bit target address and a direction bit, but only while the store enable is high. The block then waits for the clock edge strobes from a separate SCL edge detector. At each delayed falling-edge strobe it presents the next bit on the data line. The address goes out most significant bit first, and the direction bit follows it.

The data line is open-drain. The block only ever asserts a pull-down enable. When the enable is off, the line floats high through the bus pull-up. The pad level is passed through a synchronizer before the block samples it.

At each rising-edge strobe the block samples the line. During the eight frame bits it flags a bus conflict if it has released the line but sees it low. In the ninth clock it releases the line and samples the target's acknowledge. At the falling edge that ends that clock it raises done.

Top module: `i2c_addr_tx`

## Requirements
- R1: While reset (active low, synchronous) is asserted, the block releases the line and drives done, conflict and no-acknowledge low. These outputs are also low on the first cycle after reset ends.
- R2: The frame is {addr[6], ..., addr[0], rw}, sent in that order. rw=1 means read and rw=0 means write. The pull-down output is 1 exactly when the current frame bit is 0. The block never drives a high level.
- R3: The pull-down output changes only on the clock edge that samples a delayed-fall strobe. The first frame bit appears at the first such strobe after an accepted start.
- R4: A rising-edge strobe can arrive during a frame bit whose value is 1 (line released). If the synchronized line is low at that strobe, the conflict output goes high. It stays high until the next delayed-fall strobe clears it. The conflict output never goes high while the block pulls the line down.
- R5: After the eighth bit, the block releases the line for a ninth clock. The synchronized line level at that clock's rising-edge strobe becomes the no-acknowledge output: high means not acknowledged, low means acknowledged. The output holds that value until the next accepted start clears it.
- R6: Done is low from an accepted start until the delayed-fall strobe that ends the acknowledge clock. It goes high on that strobe and stays high until the next accepted start.
- R7: A start pulse with the store enable high captures the address and rw inputs. A start pulse with the store enable low sends the previously captured frame again.
- R8: A start pulse that arrives while a transfer is under way has no effect on the frame being sent or on the outputs.
- R9: Requests may follow each other directly, for example a write address and then a read address. Each request is sent correctly.
- R10: The line is sampled through a two-stage synchronizer. A low level that first appears in the same cycle as the rising-edge strobe does not flag a conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Single-cycle request pulse |
| store_en_i | input | 1 | Allows the start pulse to capture address and rw |
| addr_i | input | 7 | Target address |
| rw_i | input | 1 | Direction bit: 1 read, 0 write |
| sda_pad_i | input | 1 | Raw data line level from the pad |
| scl_rise_i | input | 1 | Single-cycle strobe for an SCL rising edge |
| scl_fall_dly_i | input | 1 | Single-cycle strobe one clock after an SCL falling edge |
| sda_pull_o | output | 1 | Pull-down enable for the open-drain data line |
| conflict_o | output | 1 | Line seen low while released during a frame bit |
| nack_o | output | 1 | Acknowledge slot sampled high |
| done_o | output | 1 | Address phase complete |

## Verification
The assertions check on every cycle the timing rules that need no knowledge of the frame. The pull-down output moves only after a delayed-fall strobe. Done rises only on that strobe and falls only on a start. No-acknowledge changes only at a rising strobe or a start. A conflict is never flagged while the block pulls the line. The captured frame holds still when a start arrives during a transfer.

Other behaviours only the bench scenarios can show. These are the bit order and polarity for every address and rw value, and which bits should flag a conflict under a given target drive pattern. They also include the acknowledge outcome, the resend of a stored frame, and the rejection of a low level that arrives too late for the synchronizer.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_BITS  = 2'd2,
    PH_ACK   = 2'd3
  } phase_e;

  // Open-drain: pull low only to send a zero.
  function automatic logic pull_for(input logic bit_val);
    return ~bit_val;
  endfunction

  // A conflict is a released line that reads low.
  function automatic logic clash(input logic released, input logic line_lvl);
    return released & ~line_lvl;
  endfunction

endpackage

// File: rtl/i2c_addr_sync.sv
module i2c_addr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= 1'b1;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_addr_frame.sv
module i2c_addr_frame #(
  parameter int ADDR_W = 7,
  localparam int FRAME_W = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rw_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) frame_q <= '0;
    else if (load_i) frame_q <= {addr_i, rw_i};
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
#(
  parameter int FRAME_W = 8,
  localparam int IDX_W = $clog2(FRAME_W),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               line_i,
  input  logic               rise_i,
  input  logic               fall_i,
  output logic               accept_o,
  output logic               busy_o,
  output logic               pull_o,
  output logic               conflict_o,
  output logic               nack_o,
  output logic               done_o
);
  phase_e            phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic              pull_q, conflict_q, nack_q, done_q;

  // Bit 0 of the sequence is the frame MSB.
  function automatic logic bit_at(input logic [FRAME_W-1:0] f, input logic [IDX_W-1:0] i);
    return f[FRAME_W-1-int'(i)];
  endfunction

  assign busy_o   = (phase_q != PH_IDLE);
  assign accept_o = start_i && !busy_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      idx_q      <= '0;
      pull_q     <= 1'b0;
      conflict_q <= 1'b0;
      nack_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q    <= PH_ARMED;
            done_q     <= 1'b0;
            nack_q     <= 1'b0;
            conflict_q <= 1'b0;
          end
        end
        PH_ARMED: begin
          if (fall_i) begin
            phase_q <= PH_BITS;
            idx_q   <= '0;
            pull_q  <= pull_for(bit_at(frame_i, '0));
          end
        end
        PH_BITS: begin
          if (fall_i) begin
            conflict_q <= 1'b0;
            if (idx_q == LAST_IDX) begin
              phase_q <= PH_ACK;
              pull_q  <= 1'b0;
            end else begin
              idx_q  <= idx_q + 1'b1;
              pull_q <= pull_for(bit_at(frame_i, idx_q + 1'b1));
            end
          end else if (rise_i) begin
            conflict_q <= clash(!pull_q, line_i);
          end
        end
        PH_ACK: begin
          if (fall_i) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else if (rise_i) begin
            nack_q <= line_i;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign pull_o     = pull_q;
  assign conflict_o = conflict_q;
  assign nack_o     = nack_q;
  assign done_o     = done_q;
endmodule

// File: rtl/i2c_addr_tx.sv
module i2c_addr_tx #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              store_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  input  logic              sda_pad_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_dly_i,
  output logic              sda_pull_o,
  output logic              conflict_o,
  output logic              nack_o,
  output logic              done_o
);
  localparam int FRAME_W = ADDR_W + 1;

  logic               line_sync;
  logic               accept_w;
  logic               xfer_busy;
  logic [FRAME_W-1:0] frame_w;

  i2c_addr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_pad_i), .q_o(line_sync)
  );

  i2c_addr_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .load_i(accept_w && store_en_i),
    .addr_i(addr_i), .rw_i(rw_i), .frame_o(frame_w)
  );

  i2c_addr_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_w),
    .line_i(line_sync), .rise_i(scl_rise_i), .fall_i(scl_fall_dly_i),
    .accept_o(accept_w), .busy_o(xfer_busy), .pull_o(sda_pull_o),
    .conflict_o(conflict_o), .nack_o(nack_o), .done_o(done_o)
  );
endmodule

// File: rtl/i2c_addr_tx_chk.sv
module i2c_addr_tx_chk #(
  parameter int FRAME_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               scl_rise_i,
  input logic               scl_fall_dly_i,
  input logic               sda_pull_o,
  input logic               conflict_o,
  input logic               nack_o,
  input logic               done_o,
  input logic               xfer_busy,
  input logic [FRAME_W-1:0] frame_w
);
  // R1: outputs idle right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!sda_pull_o && !conflict_o && !nack_o && !done_o));

  a_r3_pull_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> $past(scl_fall_dly_i));

  a_r4_no_clash_while_pulling: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> !sda_pull_o);

  a_r5_nack_moves_on_rise_or_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nack_o) |-> ($past(scl_rise_i) || $past(start_i)));

  a_r6_done_rises_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(scl_fall_dly_i));

  a_r6_done_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_o) |-> $past(start_i));

  a_r6_done_line_released: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !sda_pull_o);

  a_r8_frame_kept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && start_i) |=> $stable(frame_w));
endmodule

bind i2c_addr_tx i2c_addr_tx_chk #(.FRAME_W(ADDR_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_rise_i(scl_rise_i),
  .scl_fall_dly_i(scl_fall_dly_i), .sda_pull_o(sda_pull_o),
  .conflict_o(conflict_o), .nack_o(nack_o), .done_o(done_o),
  .xfer_busy(xfer_busy), .frame_w(frame_w)
);

// File: tb/i2c_addr_tx_tb.sv
module i2c_addr_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, store_en_i = 1'b0, rw_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic       scl_rise_i = 1'b0, scl_fall_dly_i = 1'b0;
  logic       target_low = 1'b0;
  logic       sda_pad_i;
  logic       sda_pull_o, conflict_o, nack_o, done_o;
  int         n_vec = 0, n_bad = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  // Open-drain wire-AND with the target's drive.
  assign sda_pad_i = !(sda_pull_o || target_low);

  i2c_addr_tx u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .store_en_i(store_en_i),
    .addr_i(addr_i), .rw_i(rw_i), .sda_pad_i(sda_pad_i),
    .scl_rise_i(scl_rise_i), .scl_fall_dly_i(scl_fall_dly_i),
    .sda_pull_o(sda_pull_o), .conflict_o(conflict_o),
    .nack_o(nack_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fall_pulse();
    scl_fall_dly_i = 1'b1; @(negedge clk); scl_fall_dly_i = 1'b0;
  endtask

  // One address phase. exp_frame is the frame the bench expects on the line.
  task automatic xfer(input logic [6:0] a, input logic r, input logic store,
                      input logic [7:0] exp_frame, input logic [7:0] mask,
                      input logic ack, input logic intrude, input logic late);
    start_i = 1'b1; store_en_i = store; addr_i = a; rw_i = r;
    @(negedge clk);
    start_i = 1'b0; store_en_i = 1'b0;
    check("R6 done low after start", done_o, 1'b0);
    check("R5 nack cleared by start", nack_o, 1'b0);
    idle(2);
    check("R3 line released before first fall", sda_pull_o, 1'b0);
    for (int b = 0; b < 9; b++) begin
      if (intrude && b == 4) begin
        start_i = 1'b1; store_en_i = 1'b1; addr_i = ~a; rw_i = ~r;
        @(negedge clk);
        start_i = 1'b0; store_en_i = 1'b0;
        check("R8 start in transfer keeps done low", done_o, 1'b0);
      end
      fall_pulse();
      check("R4 conflict cleared at new bit", conflict_o, 1'b0);
      if (b < 8) check("R2 frame bit polarity", sda_pull_o, !exp_frame[7-b]);
      else       check("R5 line released in ack slot", sda_pull_o, 1'b0);
      idle(2);
      if (b < 8) begin
        if (!late) target_low = mask[b];
        idle(3);
        if (late) target_low = mask[b];
        scl_rise_i = 1'b1; @(negedge clk); scl_rise_i = 1'b0;
        if (late)
          check("R10 late low not seen", conflict_o, 1'b0);
        else
          check("R4 conflict flag", conflict_o, exp_frame[7-b] & mask[b]);
        check("R3 pull held through rise", sda_pull_o, !exp_frame[7-b]);
        target_low = 1'b0;
      end else begin
        target_low = ack;
        idle(3);
        scl_rise_i = 1'b1; @(negedge clk); scl_rise_i = 1'b0;
        check("R5 nack sampled", nack_o, !ack);
        check("R6 done low in ack slot", done_o, 1'b0);
        target_low = 1'b0;
      end
      idle(2);
    end
    fall_pulse();
    check("R6 done after final fall", done_o, 1'b1);
    check("R6 line released when done", sda_pull_o, 1'b0);
    idle(2);
    check("R5 nack held after done", nack_o, !ack);
  endtask

  initial begin
    logic [7:0] held;
    idle(3);
    check("R1 reset pull", sda_pull_o, 1'b0);
    check("R1 reset done", done_o, 1'b0);
    check("R1 reset conflict", conflict_o, 1'b0);
    check("R1 reset nack", nack_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done low after reset", done_o, 1'b0);
    held = 8'h00;
    // R9: consecutive requests alternate write and read across the sweep.
    for (int i = 0; i < 256; i++) begin
      logic [6:0] a;
      logic r, store, ack, intrude, late;
      logic [7:0] mask, expf;
      a       = 7'(i >> 1);
      r       = i[0];
      mask    = 8'((i * 37 + 5) & 255);
      ack     = (i % 3) != 0;
      intrude = (i % 16) == 5;
      late    = (i % 32) == 9;
      store   = (i % 16) != 11;
      // R7: without store enable the earlier frame is resent.
      expf    = store ? {a, r} : held;
      xfer(a, r, store, expf, mask, ack, intrude, late);
      held = expf;
    end
    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule